// File: doc/BRIEF.md
# Watchdog Timer with Two-Stage Tick Divider

This block is a memory-mapped watchdog. Its input clock first passes through an 8-bit programmable prescaler and then through a selectable power-of-two divider. The result is a tick that decrements a 16-bit live counter. When a tick arrives while the counter already reads zero, the watchdog has expired. Control bits then decide what expiry raises: a system reset request held for a fixed number of clocks, a one-cycle interrupt pulse, both, or neither. On expiry the counter reloads itself from a separate reload register and keeps counting.

Software keeps the system alive by writing the live-count register. That write loads the counter at once and restarts the divider phase, so the next timeout is exactly predictable from the moment of the write. The reload register is written separately and only takes effect at the next expiry.

The register port is a plain synchronous bus with write enable, address, write data and combinational read data. Every write is accepted in the cycle it is presented, so there is no valid/ready pairing and no back-pressure. Both outputs are plain level or pulse pins.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control register reads 0 (watchdog stopped), the reload and count registers read 0x8000, and both outputs are low.
- R2: Control sits at offset 0x0, reload at 0x4 and count at 0x8. Control layout: bit 0 enable, bit 1 reset-enable, bit 2 interrupt-enable, bits 5:4 divider select, bits 15:8 prescale. Unused control bits read zero, other offsets read zero, and writes to them change nothing.
- R3: One tick lasts (prescale+1) * D clocks, where divider select 0, 1, 2 and 3 give D = 16, 32, 64 and 128.
- R4: While enabled, the count register reads the live counter, which drops by one per tick.
- R5: A write to the count register loads the counter in that cycle and restarts the tick phase, so the first decrement comes one full tick after the write edge.
- R6: A tick that finds the counter at zero is an expiry. The counter then reloads from the reload register, so the next expiry follows (reload+1) ticks later.
- R7: With interrupt-enable set, each expiry raises the interrupt output for exactly one clock, in the cycle after the expiry edge.
- R8: With reset-enable set, each expiry drives the reset request high for exactly 128 clocks, starting in the cycle after the expiry edge.
- R9: With both enables set, the interrupt and reset request rise in the same cycle. With neither set, expiry only reloads the counter.
- R10: With enable clear, the counter holds its value, the tick phase is held at zero and no output event occurs. Setting enable starts the tick phase from zero at the write edge.
- R11: Writing the reload register leaves the live counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the watchdog time base |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the register at bus_addr |
| wdog_irq | output | 1 | One-cycle interrupt pulse on expiry |
| reset_req | output | 1 | Stretched system reset request on expiry |

## Verification
The hardest situation to reach from the ports is an expiry whose exact edge is known when the tick is thousands of clocks long and the phase of the divider chain cannot be observed. The stimulus makes every count write or enable write the timing reference. Because such a write clears the divider chain, each expected event edge is computed as the reference edge plus (count+1) ticks. The stimulus then drives the prescale field to its maximum with a zero count. It also lets a keepalive stream lapse with both enables set, so that the interrupt and the reset request must land on the same computed edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int BUS_W = 32;
  localparam int PRE_W = 8;
  localparam int SEL_W = 2;

  localparam int OFS_CTRL   = 0;
  localparam int OFS_RELOAD = 4;
  localparam int OFS_COUNT  = 8;

  localparam int BIT_EN    = 0;
  localparam int BIT_RSTEN = 1;
  localparam int BIT_IRQEN = 2;
  localparam int SEL_LSB   = 4;
  localparam int PRE_LSB   = 8;

  typedef struct packed {
    logic [PRE_W-1:0] prescale;
    logic [SEL_W-1:0] div_sel;
    logic             irq_en;
    logic             rst_en;
    logic             en;
  } wdog_ctrl_t;

  function automatic wdog_ctrl_t ctrl_from_bus(input logic [BUS_W-1:0] w);
    wdog_ctrl_t c;
    c.en       = w[BIT_EN];
    c.rst_en   = w[BIT_RSTEN];
    c.irq_en   = w[BIT_IRQEN];
    c.div_sel  = w[SEL_LSB +: SEL_W];
    c.prescale = w[PRE_LSB +: PRE_W];
    return c;
  endfunction

  function automatic logic [BUS_W-1:0] ctrl_to_bus(input wdog_ctrl_t c);
    logic [BUS_W-1:0] r;
    r = '0;
    r[BIT_EN]              = c.en;
    r[BIT_RSTEN]           = c.rst_en;
    r[BIT_IRQEN]           = c.irq_en;
    r[SEL_LSB +: SEL_W]    = c.div_sel;
    r[PRE_LSB +: PRE_W]    = c.prescale;
    return r;
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16,
  parameter logic [CNT_W-1:0] RESET_CNT = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  live_count,
  output wdog_ctrl_t        ctrl,
  output logic [CNT_W-1:0]  reload_val,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  cnt_load_val,
  output logic [BUS_W-1:0]  rdata
);
  logic hit_ctrl, hit_reload, hit_count;
  wdog_ctrl_t       ctrl_q;
  logic [CNT_W-1:0] reload_q;

  assign hit_ctrl   = (addr == ADDR_W'(OFS_CTRL));
  assign hit_reload = (addr == ADDR_W'(OFS_RELOAD));
  assign hit_count  = (addr == ADDR_W'(OFS_COUNT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= RESET_CNT;
    end else if (we) begin
      if (hit_ctrl)   ctrl_q   <= ctrl_from_bus(wdata);
      if (hit_reload) reload_q <= wdata[CNT_W-1:0];
    end
  end

  assign ctrl         = ctrl_q;
  assign reload_val   = reload_q;
  assign cnt_load     = we && hit_count;
  assign cnt_load_val = wdata[CNT_W-1:0];

  always_comb begin
    rdata = '0;
    if (hit_ctrl)        rdata = ctrl_to_bus(ctrl_q);
    else if (hit_reload) rdata = BUS_W'(reload_q);
    else if (hit_count)  rdata = BUS_W'(live_count);
  end
endmodule

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen
  import wdog_pkg::*;
#(
  parameter int BASE_DIV_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] prescale,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  localparam int DIV_W = BASE_DIV_LOG2 + (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W:0]   div_len;
  logic [DIV_W-1:0] div_last;
  logic             pre_wrap, div_wrap;

  assign div_len  = (DIV_W+1)'(1) << (BASE_DIV_LOG2 + int'(div_sel));
  assign div_last = DIV_W'(div_len - (DIV_W+1)'(1));

  // >= keeps a shrinking field from wrapping through the full range
  assign pre_wrap = (pre_q >= prescale);
  assign div_wrap = (div_q >= div_last);
  assign tick     = run && pre_wrap && div_wrap;

  always_ff @(posedge clk) begin
    if (!rst_n || !run || restart) begin
      pre_q <= '0;
      div_q <= '0;
    end else if (pre_wrap) begin
      pre_q <= '0;
      if (div_wrap) div_q <= '0;
      else          div_q <= div_q + DIV_W'(1);
    end else begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] RESET_CNT = 16'h8000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] count_q;

  assign expire = tick && !load && (count_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                 count_q <= RESET_CNT;
    else if (load)              count_q <= load_val;
    else if (tick) begin
      if (count_q == '0)        count_q <= reload_val;
      else                      count_q <= count_q - CNT_W'(1);
    end
  end

  assign count = count_q;
endmodule

// File: rtl/wdog_event.sv
module wdog_event #(
  parameter int RST_LEN = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic irq_en,
  input  logic rst_en,
  output logic irq,
  output logic reset_req
);
  logic irq_q;
  logic fire_rst;

  assign fire_rst = expire && rst_en;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= expire && irq_en;
  end
  assign irq = irq_q;

  generate
    if (RST_LEN <= 1) begin : g_rst_flop
      logic rst_q;
      always_ff @(posedge clk) begin
        if (!rst_n) rst_q <= 1'b0;
        else        rst_q <= fire_rst;
      end
      assign reset_req = rst_q;
    end else begin : g_rst_stretch
      localparam int RW = $clog2(RST_LEN + 1);
      logic [RW-1:0] left_q;
      always_ff @(posedge clk) begin
        if (!rst_n)              left_q <= '0;
        else if (fire_rst)       left_q <= RW'(RST_LEN);
        else if (left_q != '0)   left_q <= left_q - RW'(1);
      end
      assign reset_req = (left_q != '0);
    end
  endgenerate
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter int CNT_W         = 16,
  parameter int BASE_DIV_LOG2 = 4,
  parameter int RST_LEN       = 128,
  parameter logic [CNT_W-1:0] RESET_CNT = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wdog_irq,
  output logic              reset_req
);
  wdog_ctrl_t       ctl;
  logic [CNT_W-1:0] reload_val, live_count, load_val;
  logic             cnt_load, tick, expire;
  logic             ctl_en, ctl_rst_en, ctl_irq_en;

  assign ctl_en     = ctl.en;
  assign ctl_rst_en = ctl.rst_en;
  assign ctl_irq_en = ctl.irq_en;

  wdog_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .RESET_CNT(RESET_CNT)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .live_count(live_count), .ctrl(ctl), .reload_val(reload_val),
    .cnt_load(cnt_load), .cnt_load_val(load_val), .rdata(bus_rdata)
  );

  wdog_tick_gen #(.BASE_DIV_LOG2(BASE_DIV_LOG2)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(ctl_en), .restart(cnt_load),
    .prescale(ctl.prescale), .div_sel(ctl.div_sel), .tick(tick)
  );

  wdog_counter #(.CNT_W(CNT_W), .RESET_CNT(RESET_CNT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_load),
    .load_val(load_val), .reload_val(reload_val),
    .count(live_count), .expire(expire)
  );

  wdog_event #(.RST_LEN(RST_LEN)) u_evt (
    .clk(clk), .rst_n(rst_n), .expire(expire), .irq_en(ctl_irq_en),
    .rst_en(ctl_rst_en), .irq(wdog_irq), .reset_req(reset_req)
  );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int ADDR_W  = 4,
  parameter int CNT_W   = 16,
  parameter int RST_LEN = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              wdog_irq,
  input logic              reset_req,
  input logic              en,
  input logic              irq_en,
  input logic              rst_en,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  reload
);
  localparam int RW = $clog2(RST_LEN + 2);
  logic          count_wr;
  logic [RW-1:0] run_q;

  assign count_wr = bus_we && (bus_addr == ADDR_W'(8));

  always_ff @(posedge clk) begin
    if (!rst_n)                        run_q <= '0;
    else if (!reset_req)               run_q <= '0;
    else if (run_q < RW'(RST_LEN))     run_q <= run_q + RW'(1);
  end

  a_r7_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_irq |=> !wdog_irq);

  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_irq |-> $past(irq_en));

  a_r8_rst_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_req) |-> $past(rst_en));

  a_r8_rst_min_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reset_req) |-> (run_q >= RW'(RST_LEN)));

  a_r5_count_load: assert property (@(posedge clk) disable iff (!rst_n)
    count_wr |=> (count == $past(bus_wdata[CNT_W-1:0])));

  a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !count_wr) |=> $stable(count));

  a_r10_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!wdog_irq && !$rose(reset_req)));

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !count_wr) |=> (count == $past(count) ||
                           count == $past(count) - CNT_W'(1) ||
                           ($past(count) == '0 && count == $past(reload))));
endmodule

bind wdog_timer wdog_timer_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .RST_LEN(RST_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .wdog_irq(wdog_irq), .reset_req(reset_req),
  .en(ctl_en), .irq_en(ctl_irq_en), .rst_en(ctl_rst_en),
  .count(live_count), .reload(reload_val)
);

// File: tb/wdog_timer_tb.sv
`timescale 1ns/1ps
module wdog_timer_tb;
  localparam int EV_IRQ = 1;
  localparam int EV_RST = 2;
  localparam logic [3:0] A_CTRL = 4'h0, A_REL = 4'h4, A_CNT = 4'h8;

  typedef struct { int kind; int cyc; } ev_t;
  ev_t exp_q[$];

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic wdog_irq, reset_req;

  int cyc = 0;
  int nchecks = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdog_irq(wdog_irq), .reset_req(reset_req)
  );

  function automatic logic [31:0] mk_ctrl(int pre, int sel, bit irqen, bit rsten, bit en);
    return {16'h0, 8'(pre), 2'b00, 2'(sel), 1'b0, irqen, rsten, en};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, output int e);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    e = cyc;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d, output int k);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
    k = cyc;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic push_ev(input int kind, input int c);
    ev_t e;
    e.kind = kind; e.cyc = c;
    exp_q.push_back(e);
  endtask

  // monitor: pops expected events and compares kind and cycle
  bit irq_prev = 1'b0, rst_prev = 1'b0;
  int rst_run = 0;

  task automatic take_ev(input int kind, input string req);
    ev_t e;
    nchecks++;
    if (exp_q.size() == 0) begin
      nfail++;
      $display("FAIL %s unexpected event kind=%0d actual_cyc=%0d expected=none", req, kind, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.cyc != cyc) begin
        nfail++;
        $display("FAIL %s event actual kind=%0d cyc=%0d expected kind=%0d cyc=%0d",
                 req, kind, cyc, e.kind, e.cyc);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (wdog_irq) begin
        take_ev(EV_IRQ, "R7");
        if (irq_prev) chk("R7 pulse width", 32'd2, 32'd1);
      end
      if (reset_req && !rst_prev) take_ev(EV_RST, "R8");
      if (reset_req) rst_run++;
      else if (rst_prev) begin
        chk("R8 reset width", 32'(rst_run), 32'd128);
        rst_run = 0;
      end
      irq_prev = wdog_irq;
      rst_prev = reset_req;
    end
  end

  always @(negedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      nfail++;
      $display("FAIL watchdog expired actual_cyc=%0d expected=finish", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    int w, k, e;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_CTRL, d, k); chk("R1 ctrl", d, 32'h0);
    rd(A_REL, d, k);  chk("R1 reload", d, 32'h8000);
    rd(A_CNT, d, k);  chk("R1 count", d, 32'h8000);
    chk("R1 outputs", {30'h0, wdog_irq, reset_req}, 32'h0);

    // R2 control layout and reserved bits
    wr(A_CTRL, mk_ctrl(8'hA5, 2, 0, 0, 0), e);
    rd(A_CTRL, d, k); chk("R2 ctrl fields", d, 32'h0000_A520);
    wr(A_CTRL, 32'hFFFF_00C8, e);
    rd(A_CTRL, d, k); chk("R2 reserved zero", d, 32'h0);

    // R2 unmapped offset
    wr(4'hC, 32'h1234, e);
    rd(4'hC, d, k);   chk("R2 unmapped read", d, 32'h0);
    rd(A_REL, d, k);  chk("R2 unmapped write reload", d, 32'h8000);
    rd(A_CNT, d, k);  chk("R2 unmapped write count", d, 32'h8000);

    // R11 reload write leaves count
    wr(A_REL, 32'd5, e);
    rd(A_CNT, d, k);  chk("R11 count untouched", d, 32'h8000);
    rd(A_REL, d, k);  chk("R11 reload value", d, 32'd5);

    // R10 disabled: frozen
    wait_until(cyc + 200);
    rd(A_CNT, d, k);  chk("R10 disabled frozen", d, 32'h8000);

    // R6 R7 interrupt mode, N=16, count 3, reload 5
    wr(A_CNT, 32'd3, e);
    wr(A_CTRL, mk_ctrl(0, 0, 1, 0, 1), w);
    push_ev(EV_IRQ, w + 4*16);
    push_ev(EV_IRQ, w + 4*16 + 6*16);
    wait_until(w + 20);
    rd(A_CNT, d, k);  chk("R4 live count", d, 32'(3 - (k - w) / 16));
    wait_until(w + 170);
    wr(A_CTRL, 32'h0, e);
    rd(A_CNT, d, k);  chk("R6 reload after expiry", d, 32'd5);

    // R3 prescale 2, select 1: N = 3*32 = 96
    wr(A_CNT, 32'd2, e);
    wr(A_CTRL, mk_ctrl(2, 1, 1, 0, 1), w);
    push_ev(EV_IRQ, w + 3*96);
    wait_until(w + 300);
    wr(A_CTRL, 32'h0, e);

    // R3 select 3: N = 128
    wr(A_CNT, 32'd1, e);
    wr(A_CTRL, mk_ctrl(0, 3, 1, 0, 1), w);
    push_ev(EV_IRQ, w + 2*128);
    wait_until(w + 260);
    wr(A_CTRL, 32'h0, e);

    // R3 maximum prescale, count 0: N = 256*16
    wr(A_CNT, 32'd0, e);
    wr(A_CTRL, mk_ctrl(255, 0, 1, 0, 1), w);
    push_ev(EV_IRQ, w + 4096);
    wait_until(w + 4100);
    wr(A_CTRL, 32'h0, e);

    // R5 keepalive, then R9 both outputs on lapse
    wr(A_REL, 32'd20, e);
    wr(A_CNT, 32'd2, e);
    wr(A_CTRL, mk_ctrl(0, 0, 1, 1, 1), w);
    for (int i = 0; i < 10; i++) begin
      wait_until(w + 30);
      wr(A_CNT, 32'd2, w);
    end
    push_ev(EV_IRQ, w + 3*16);
    push_ev(EV_RST, w + 3*16);
    wait_until(w + 20);
    rd(A_CNT, d, k);  chk("R5 keepalive count", d, 32'(2 - (k - w) / 16));
    wait_until(w + 48 + 140);
    // stop: clear enable and reset-enable
    wr(A_CTRL, mk_ctrl(0, 0, 1, 0, 0), e);
    rd(A_CNT, d, k);
    wait_until(cyc + 600);
    rd(A_CNT, d2, k); chk("R10 stopped count stable", d2, d);

    // R8 reset only
    wr(A_CNT, 32'd1, e);
    wr(A_CTRL, mk_ctrl(0, 0, 0, 1, 1), w);
    push_ev(EV_RST, w + 2*16);
    wait_until(w + 32 + 140);
    wr(A_CTRL, 32'h0, e);

    // R9 neither output enabled: silent reload
    wr(A_CNT, 32'd0, e);
    wr(A_CTRL, mk_ctrl(0, 0, 0, 0, 1), w);
    wait_until(w + 22);
    rd(A_CNT, d, k);  chk("R9 silent reload", d, 32'(20 - (k - w - 16) / 16));
    wr(A_CTRL, 32'h0, e);

    wait_until(cyc + 50);
    chk("R6 R7 R8 pending events", 32'(exp_q.size()), 32'd0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule